// File: doc/BRIEF.md
# ARINC 429 Word Transmitter

This block takes 32-bit transmit words from a 16-bit host bus and sends them on a serial line as bipolar return-to-zero level pairs. A word arrives in two halves. The first strobe holds the low half in a staging register. The second strobe supplies the high half and commits the whole word to an eight-entry FIFO. When the enable input is high and the FIFO holds data, the block starts a burst. It sends the queued words one after another, and a fixed null gap follows each word.

The parity bit in each host word is discarded. At send time the block recomputes bit 31 from the programmed parity sense. A ready flag is high only when the serialiser is idle and the FIFO is empty. In the usual hookup the enable input is the inverse of this flag, so a burst begins as soon as the first word is committed. The host may add words only while the first word of a burst is in flight. After the second word starts, further writes are ignored until the burst ends. A write that finds the FIFO full is dropped and sets a sticky overflow flag.

Top module: `a429_tx`

## Requirements
- R1: The FIFO holds up to DEPTH (8) committed words. One burst sends them all, in commit order.
- R2: `load_lo` only stages `host_data` as word bits 15:0. Nothing is queued, and `tx_ready` stays high, until `load_hi` commits `{host_data, staged}` as bits 31:16 and 15:0.
- R3: Host bit 31 has no effect. The transmitted bit 31 makes the count of ones in all 32 bits odd when `parity_odd`=1, and even when `parity_odd`=0. `parity_odd` is sampled when the word starts.
- R4: `tx_ready` is 1 exactly when no word or gap is being sent and the FIFO is empty. It is 1 after reset, goes low one cycle after a commit, and is still low when the last data bit of a burst has been sent.
- R5: Writes are accepted while idle and during the first word of a burst (including its gap). Once the second word starts, `load_lo` and `load_hi` are ignored until the burst ends.
- R6: After bit 31 of a word, the line stays null for half a bit plus GAP_BITS (4) full bit-times before the next word's bit 0.
- R7: Bits go out LSB first (bit 0 first). Each bit lasts 2*CLKS_PER_HALF cycles. For the first CLKS_PER_HALF cycles `line_hi`=1 for a one or `line_lo`=1 for a zero. For the rest, both lines are 0.
- R8: A `load_hi` that would be accepted but finds the FIFO full is dropped and sets `overflow`. `overflow` stays set until reset.
- R9: A word starts only when `tx_enable` is high. If `tx_enable` is low at a word boundary, the burst ends and the remaining words stay queued with `tx_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_data | input | 16 | Host write data |
| load_lo | input | 1 | Stage the low half of a word |
| load_hi | input | 1 | Supply the high half and commit the word |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| tx_enable | input | 1 | Allows a word to start |
| line_hi | output | 1 | Drive line high (one-bit level) |
| line_lo | output | 1 | Drive line low (zero-bit level) |
| tx_ready | output | 1 | Idle with FIFO empty |
| overflow | output | 1 | Sticky: a write found the FIFO full |

## Verification
A line decoder in the bench rebuilds every word from the level pair. It also times each level half, each null half and each inter-word gap. Single words are sent under both parity senses, with a deliberately wrong host parity bit, which shows that the sent bit 31 comes from the programmed setting. A full eight-word burst is queued with the enable held low and then overfilled. This separates queuing from sending and exercises the overflow path. Writes are also placed inside the first word and after the second word starts, and the enable is dropped in mid-burst. Together these show which writes reach the line and where a burst stops.

// File: rtl/a429_tx.sv
module a429_tx #(
  parameter int DEPTH         = 8,
  parameter int CLKS_PER_HALF = 4,
  parameter int GAP_BITS      = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] host_data,
  input  logic        load_lo,
  input  logic        load_hi,
  input  logic        parity_odd,
  input  logic        tx_enable,
  output logic        line_hi,
  output logic        line_lo,
  output logic        tx_ready,
  output logic        overflow
);
  localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int GAP_CLKS = GAP_BITS * 2 * CLKS_PER_HALF;
  localparam int CW       = $clog2(GAP_CLKS + 1);

  typedef enum logic [1:0] {IDLE, DATA, GAP} st_t;
  st_t st;

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic [15:0]   lo_stage;
  logic [31:0]   shreg;
  logic          par_r;
  logic [4:0]    bitn;
  logic          phase;
  logic          first;
  logic [CW-1:0] tcnt;

  wire empty    = (cnt == '0);
  wire full     = (cnt == (AW+1)'(DEPTH));
  wire accept   = (st == IDLE) || first;
  wire push     = load_hi && accept && !full;
  wire half_end = (tcnt == CW'(CLKS_PER_HALF - 1));
  wire gap_end  = (st == GAP) && (tcnt == CW'(GAP_CLKS - 1));
  wire start    = tx_enable && !empty && ((st == IDLE) || gap_end);
  wire pop      = start;
  wire [31:0] nw = mem[rp];
  wire cur_bit  = (bitn == 5'd31) ? par_r : shreg[0];

  assign line_hi  = (st == DATA) && !phase && cur_bit;
  assign line_lo  = (st == DATA) && !phase && !cur_bit;
  assign tx_ready = (st == IDLE) && empty;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {host_data, lo_stage};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; lo_stage <= '0; overflow <= 1'b0;
    end else begin
      if (load_lo && accept) lo_stage <= host_data;
      if (load_hi && accept && full) overflow <= 1'b1;
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; shreg <= '0; par_r <= 1'b0; bitn <= '0;
      phase <= 1'b0; first <= 1'b0; tcnt <= '0;
    end else if (start) begin
      st    <= DATA;
      shreg <= nw;
      par_r <= parity_odd ^ (^nw[30:0]);
      bitn  <= '0;
      phase <= 1'b0;
      tcnt  <= '0;
      first <= (st == IDLE);
    end else begin
      case (st)
        DATA: begin
          if (half_end) begin
            tcnt  <= '0;
            phase <= ~phase;
            if (phase) begin
              shreg <= {1'b0, shreg[31:1]};
              bitn  <= bitn + 1'b1;
              if (bitn == 5'd31) st <= GAP;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        GAP: begin
          if (gap_end) begin
            st   <= IDLE;
            tcnt <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: tcnt <= '0;
      endcase
    end
  end

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));
  assert_blocked_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_hi && !accept && !pop) |=> (cnt == $past(cnt)));
  assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_hi && full && !pop) |=> (cnt == $past(cnt)));
  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  assert_gap_null_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == GAP) |-> (!line_hi && !line_lo));
  assert_rz_null_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == DATA && phase) |-> (!line_hi && !line_lo));
  assert_enable_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && !tx_enable) |=> (st == IDLE));
endmodule

// File: tb/a429_tx_tb_top.sv
module a429_tx_tb_top;
  localparam int CPH = 4;
  localparam int GAPB = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] host_data = '0;
  logic load_lo = 1'b0, load_hi = 1'b0, par_odd = 1'b1;
  logic auto_en = 1'b1, man_en = 1'b0;
  logic line_hi, line_lo, tx_ready, overflow;
  wire  tx_enable = auto_en ? ~tx_ready : man_en;

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  a429_tx #(.DEPTH(8), .CLKS_PER_HALF(CPH), .GAP_BITS(GAPB)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_data(host_data), .load_lo(load_lo),
    .load_hi(load_hi), .parity_odd(par_odd), .tx_enable(tx_enable),
    .line_hi(line_hi), .line_lo(line_lo), .tx_ready(tx_ready), .overflow(overflow));

  always #10 clk = ~clk;

  logic [31:0] rx_words [64];
  int rx_n = 0, bitcnt = 0, run = 0, null_run = 1000;
  bit prev_act = 1'b0, have_word = 1'b0;
  logic [31:0] cur = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit act;
    act = line_hi | line_lo;
    if (line_hi && line_lo) check(1'b0, "R7 both lines", 32'd1, 32'd0);
    if (act && !prev_act) begin
      if (bitcnt == 0) begin
        if (have_word) check(null_run >= CPH + GAPB*2*CPH, "R6 gap", null_run, CPH + GAPB*2*CPH);
      end else begin
        check(null_run == CPH, "R7 null half", null_run, CPH);
      end
      cur[bitcnt] = line_hi;
      bitcnt++;
      run = 1;
    end else if (act) begin
      run++;
    end else if (prev_act) begin
      check(run == CPH, "R7 level half", run, CPH);
      null_run = 1;
      if (bitcnt == 32) begin
        if (rx_n < 64) rx_words[rx_n] = cur;
        rx_n++;
        bitcnt = 0;
        have_word = 1'b1;
      end
    end else begin
      null_run++;
    end
    prev_act = act;
  end

  task automatic tick(); @(negedge clk); #1; endtask

  function automatic logic [31:0] expw(input logic [31:0] w, input bit odd);
    return {odd ^ (^w[30:0]), w[30:0]};
  endfunction

  task automatic write_word(input logic [31:0] w);
    tick(); host_data = w[15:0]; load_lo = 1'b1;
    tick(); load_lo = 1'b0; host_data = w[31:16]; load_hi = 1'b1;
    tick(); load_hi = 1'b0; host_data = '0;
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!tx_ready && n < 20000) begin tick(); n++; end
  endtask

  task automatic do_reset();
    tick(); rst_n = 1'b0;
    tick(); tick(); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    check(tx_ready == 1'b1, "R4 reset ready", tx_ready, 1);
    check(overflow == 1'b0, "R8 reset overflow", overflow, 0);
    check(!line_hi && !line_lo, "R7 reset lines", {line_hi, line_lo}, 0);
  endtask

  task automatic t_stage_only();
    int base = rx_n;
    auto_en = 1'b1;
    tick(); host_data = 16'h1234; load_lo = 1'b1;
    tick(); load_lo = 1'b0; host_data = '0;
    repeat (40) tick();
    check(tx_ready == 1'b1, "R2 stage keeps ready", tx_ready, 1);
    check(rx_n == base && bitcnt == 0, "R2 nothing sent", rx_n - base, 0);
  endtask

  task automatic t_single(input logic [31:0] w, input bit odd);
    int base = rx_n;
    auto_en = 1'b1; par_odd = odd;
    write_word(w);
    check(tx_ready == 1'b0, "R4 ready low after commit", tx_ready, 0);
    while (rx_n == base) tick();
    check(tx_ready == 1'b0, "R4 ready low at last bit", tx_ready, 0);
    wait_ready();
    check(rx_n == base + 1, "R7 one word", rx_n - base, 1);
    check(rx_words[base] == expw(w, odd), "R3 word and parity", rx_words[base], expw(w, odd));
  endtask

  task automatic t_burst8();
    int base = rx_n;
    logic [31:0] w [8];
    auto_en = 1'b0; man_en = 1'b0; par_odd = 1'b0;
    for (int i = 0; i < 8; i++) begin
      w[i] = 32'h9A5C_0000 ^ (32'h0101_1357 * (i + 1));
      write_word(w[i]);
    end
    repeat (50) tick();
    check(tx_ready == 1'b0 && rx_n == base && bitcnt == 0, "R9 held while disabled", {tx_ready, 8'(rx_n - base)}, 0);
    check(overflow == 1'b0, "R8 no overflow at eight", overflow, 0);
    write_word(32'hDEAD_BEEF);
    check(overflow == 1'b1, "R8 overflow set", overflow, 1);
    man_en = 1'b1;
    wait_ready();
    check(rx_n == base + 8, "R1 eight words", rx_n - base, 8);
    for (int i = 0; i < 8; i++)
      check(rx_words[base + i] == expw(w[i], 1'b0), "R1 order and content", rx_words[base + i], expw(w[i], 1'b0));
    check(overflow == 1'b1, "R8 overflow sticky", overflow, 1);
    do_reset();
    check(overflow == 1'b0, "R8 overflow cleared by reset", overflow, 0);
  endtask

  task automatic t_late_write();
    int base = rx_n;
    auto_en = 1'b1; par_odd = 1'b1;
    write_word(32'h0F0F_00AA);
    write_word(32'h8000_5501);
    while (!(rx_n == base + 1 && bitcnt >= 1)) tick();
    write_word(32'h7777_3333);
    wait_ready();
    check(rx_n == base + 2, "R5 late write dropped", rx_n - base, 2);
    check(rx_words[base] == expw(32'h0F0F_00AA, 1'b1), "R5 first word", rx_words[base], expw(32'h0F0F_00AA, 1'b1));
    check(rx_words[base + 1] == expw(32'h8000_5501, 1'b1), "R5 word added during first", rx_words[base + 1], expw(32'h8000_5501, 1'b1));
    repeat (20) tick();
    check(tx_ready == 1'b1, "R5 nothing left queued", tx_ready, 1);
  endtask

  task automatic t_enable_drop();
    int base = rx_n;
    auto_en = 1'b0; man_en = 1'b1; par_odd = 1'b0;
    write_word(32'h1111_2222);
    write_word(32'h3333_4444);
    while (bitcnt < 1) tick();
    man_en = 1'b0;
    repeat (600) tick();
    check(rx_n == base + 1, "R9 burst stops", rx_n - base, 1);
    check(tx_ready == 1'b0, "R9 word held, ready low", tx_ready, 0);
    man_en = 1'b1;
    wait_ready();
    check(rx_n == base + 2, "R9 resumes", rx_n - base, 2);
    check(rx_words[base + 1] == expw(32'h3333_4444, 1'b0), "R9 held word", rx_words[base + 1], expw(32'h3333_4444, 1'b0));
    auto_en = 1'b1;
  endtask

  initial begin
    t_reset();
    t_stage_only();
    t_single(32'h8000_0001, 1'b1);
    t_single(32'h0000_0003, 1'b0);
    t_single(32'hFFFF_FFFF, 1'b1);
    t_burst8();
    t_late_write();
    t_enable_drop();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "watchdog", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule